// File: doc/BRIEF.md
# T1 Remote Alarm Detector

This block watches a framed T1 receive stream and raises one flag when the far end signals a remote (yellow) alarm. The alarm can be carried in three ways, and the detector has a mode for each. In the first D4 mode it looks at the second bit of every channel byte. In the second D4 mode it looks at the framing bit in the last slot of the superframe. In ESF mode it looks for a fixed 16-bit code word in the facility data link. Each mode has its own set rule and its own clear rule, so the flag has hysteresis.

The upstream framer supplies the channel bytes, the framing bits with their superframe position, and the data-link bits. Each of these comes with its own strobe. The framer also marks the first data-link bit after frame sync. Two control inputs select the mode. The flag is registered, and it changes only on the cycle after the strobe that completes a decision.

Top module: `t1_remote_alarm_det`

## Requirements
- R1: While `rst_n` is low, `alarm` is 0, and it is still 0 on the first cycle after reset is released.
- R2: Bit-2 mode (`esf_mode`=0, `d4_fbit_sel`=0). Channel strobes are counted in back-to-back blocks of 256. After the 256th strobe of a block, if `ch_data[6]` (the second bit sent, counting from the MSB) was 0 in at least 254 of those strobes, `alarm` is 1 from the next cycle.
- R3: Bit-2 mode. After the 256th strobe of a block in which `ch_data[6]` was 0 in 253 or fewer channels, `alarm` is 0 from the next cycle.
- R4: Bit-2 mode. `alarm` does not change except on the cycle after the last strobe of a 256-channel block.
- R5: F-bit mode (`esf_mode`=0, `d4_fbit_sel`=1). Only framing strobes with `fbit_pos`=11 count; this is the 12th bit, with positions numbered from 0. When two such strobes in a row carry the same value, `alarm` takes that value on the next cycle. Framing strobes at any other position have no effect.
- R6: ESF mode (`esf_mode`=1). Data-link bits are collected into non-overlapping 16-bit groups, with the first bit received as the MSB. A group matches when it equals 16'h00FF. When 16 consecutive groups match, `alarm` is 1 from the cycle after the last bit of the 16th group.
- R7: ESF mode. Groups are also counted in back-to-back blocks of 16. If a block holds 14 or fewer matching groups, `alarm` is 0 from the cycle after that block's last bit. If the set rule of R6 is met on the same group, the set wins.
- R8: ESF mode. A data-link strobe with `fdl_sync`=1 makes its bit the first bit of a new group. Any partly collected group is dropped, and the block count and the consecutive-match count carry on.
- R9: A change in the selected mode sets `alarm` to 0 on the next cycle and restarts every count. A strobe that arrives in the same cycle as the change is ignored.
- R10: Strobes that belong to a mode other than the selected one have no effect on `alarm` or on the counts of the selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| esf_mode | input | 1 | 1 selects ESF data-link detection |
| d4_fbit_sel | input | 1 | In D4: 0 selects bit-2 mode, 1 selects F-bit mode |
| ch_valid | input | 1 | Channel byte strobe |
| ch_data | input | 8 | Channel byte, MSB sent first |
| fbit_valid | input | 1 | Framing bit strobe |
| fbit_pos | input | 4 | Framing bit position in the superframe, 0 to 11 |
| fbit_val | input | 1 | Framing bit value |
| fdl_valid | input | 1 | Data-link bit strobe |
| fdl_sync | input | 1 | Marks the first data-link bit after frame sync |
| fdl_bit | input | 1 | Data-link bit value |
| alarm | output | 1 | Remote alarm flag |

## Verification
Every decision is made on a single strobe: the 256th channel, a 12th framing bit, or the last bit of a data-link group. The new flag value is due exactly one clock after that strobe. The bench drives each strobe for one cycle starting at a falling edge, updates its model of the requirements, and compares `alarm` at the next falling edge. It also compares after every other strobe and after every idle cycle, and that is how it checks that the flag holds between decisions. Mode changes are checked the same way, one cycle after the control inputs change.

// File: rtl/t1_remote_alarm_det.sv
module t1_remote_alarm_det #(
  parameter int CH_BLOCK     = 256,
  parameter int B2_SET_MIN   = 254,
  parameter int FPOS_W       = 4,
  parameter int FBIT_IDX     = 11,
  parameter int PAT_W        = 16,
  parameter logic [PAT_W-1:0] PATTERN = 16'h00FF,
  parameter int ESF_RUN      = 16,
  parameter int ESF_BLOCK    = 16,
  parameter int ESF_CLR_MAX  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              esf_mode,
  input  logic              d4_fbit_sel,
  input  logic              ch_valid,
  input  logic [7:0]        ch_data,
  input  logic              fbit_valid,
  input  logic [FPOS_W-1:0] fbit_pos,
  input  logic              fbit_val,
  input  logic              fdl_valid,
  input  logic              fdl_sync,
  input  logic              fdl_bit,
  output logic              alarm
);
  localparam int CHW = $clog2(CH_BLOCK);
  localparam int ZW  = $clog2(CH_BLOCK + 1);
  localparam int BW  = $clog2(PAT_W);
  localparam int RW  = $clog2(ESF_RUN + 1);
  localparam int GW  = $clog2(ESF_BLOCK);
  localparam int MW  = $clog2(ESF_BLOCK + 1);

  typedef enum logic [1:0] {M_B2, M_FB, M_ESF} mode_e;

  mode_e            mode_q, cur_mode;
  logic [CHW-1:0]   ch_cnt;
  logic [ZW-1:0]    zero_cnt;
  logic             fb_prev, fb_have;
  logic [PAT_W-1:0] sh;
  logic [BW-1:0]    bit_idx;
  logic [RW-1:0]    run;
  logic [GW-1:0]    grp;
  logic [MW-1:0]    hits;
  logic             alarm_q;

  assign cur_mode = esf_mode ? M_ESF : (d4_fbit_sel ? M_FB : M_B2);

  wire              mode_chg = cur_mode != mode_q;
  wire              b2_en    = mode_q == M_B2 && !mode_chg && ch_valid;
  wire              b2_last  = ch_cnt == CHW'(CH_BLOCK - 1);
  wire [ZW-1:0]     b2_total = zero_cnt + ZW'(!ch_data[6]);
  wire              fb_en    = mode_q == M_FB && !mode_chg && fbit_valid &&
                               fbit_pos == FPOS_W'(FBIT_IDX);
  wire              es_en    = mode_q == M_ESF && !mode_chg && fdl_valid;
  wire [BW-1:0]     pos      = fdl_sync ? '0 : bit_idx;
  wire [PAT_W-1:0]  word     = {sh[PAT_W-2:0], fdl_bit};
  wire              grp_done = es_en && pos == BW'(PAT_W - 1);
  wire              hit      = word == PATTERN;
  wire [RW-1:0]     run_nx   = !hit ? '0 : (run == RW'(ESF_RUN) ? run : run + 1'b1);
  wire              blk_end  = grp == GW'(ESF_BLOCK - 1);
  wire [MW-1:0]     hits_tot = hits + MW'(hit);

  always_ff @(posedge clk) begin
    if (!rst_n || mode_chg) begin
      mode_q   <= rst_n ? cur_mode : M_B2;
      ch_cnt   <= '0;
      zero_cnt <= '0;
      fb_prev  <= 1'b0;
      fb_have  <= 1'b0;
      sh       <= '0;
      bit_idx  <= '0;
      run      <= '0;
      grp      <= '0;
      hits     <= '0;
      alarm_q  <= 1'b0;
    end else begin
      if (b2_en) begin
        if (b2_last) begin
          alarm_q  <= b2_total >= ZW'(B2_SET_MIN);
          ch_cnt   <= '0;
          zero_cnt <= '0;
        end else begin
          ch_cnt   <= ch_cnt + 1'b1;
          zero_cnt <= b2_total;
        end
      end
      if (fb_en) begin
        if (fb_have && fbit_val == fb_prev) alarm_q <= fbit_val;
        fb_prev <= fbit_val;
        fb_have <= 1'b1;
      end
      if (es_en) begin
        sh      <= word;
        bit_idx <= pos + 1'b1;
        if (grp_done) begin
          run  <= run_nx;
          grp  <= blk_end ? '0 : grp + 1'b1;
          hits <= blk_end ? '0 : hits_tot;
          if (run_nx == RW'(ESF_RUN))
            alarm_q <= 1'b1;
          else if (blk_end && hits_tot <= MW'(ESF_CLR_MAX))
            alarm_q <= 1'b0;
        end
      end
    end
  end

  assign alarm = alarm_q;

  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> !alarm);

  assert_mode_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !alarm);

  assert_b2_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_B2 && !mode_chg && !(ch_valid && b2_last)) |=> $stable(alarm));

  assert_fbit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FB && !mode_chg && !fb_en) |=> $stable(alarm));

  assert_esf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_done && hit && run == RW'(ESF_RUN - 1)) |=> alarm);

  assert_esf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ESF && !mode_chg && !grp_done) |=> $stable(alarm));
endmodule

// File: tb/tb_t1_remote_alarm_det.sv
module tb_t1_remote_alarm_det;
  logic clk = 0, rst_n = 0;
  logic esf_mode = 0, d4_fbit_sel = 0;
  logic ch_valid = 0, fbit_valid = 0, fbit_val = 0, fdl_valid = 0, fdl_sync = 0, fdl_bit = 0;
  logic [7:0] ch_data = 0;
  logic [3:0] fbit_pos = 0;
  logic alarm;

  t1_remote_alarm_det dut (.*);

  always #10 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  int seed = 1234;
  // bench model of the requirements
  int m_mode = 0, m_cnt = 0, m_zero = 0, m_pos = 0, m_run = 0, m_grp = 0, m_hits = 0;
  bit m_fprev = 0, m_fhave = 0, exp_a = 0;
  logic [15:0] m_sh = 0;

  function automatic int mode_of(bit e, bit s);
    return e ? 2 : (s ? 1 : 0);
  endfunction

  function automatic bit b2_decide(int zeros);
    return zeros >= 254;
  endfunction

  task automatic check(string req);
    n_vec++;
    if (alarm !== exp_a) begin
      n_bad++;
      $display("FAIL %s: alarm=%b expected=%b at %0t", req, alarm, exp_a, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_zero = 0; m_pos = 0; m_run = 0; m_grp = 0; m_hits = 0;
    m_fprev = 0; m_fhave = 0; m_sh = 0; exp_a = 0;
  endtask

  task automatic set_mode(bit e, bit s, string req);
    esf_mode = e; d4_fbit_sel = s;
    @(negedge clk);
    if (mode_of(e, s) != m_mode) begin
      m_mode = mode_of(e, s);
      model_reset();
    end
    check(req);
  endtask

  task automatic idle(string req);
    @(negedge clk);
    check(req);
  endtask

  task automatic ch(logic [7:0] d, string req);
    ch_valid = 1; ch_data = d;
    @(negedge clk);
    ch_valid = 0;
    if (m_mode == 0) begin
      m_zero += (d[6] == 0);
      if (m_cnt == 255) begin
        exp_a = b2_decide(m_zero);
        m_cnt = 0; m_zero = 0;
      end else m_cnt++;
    end
    check(req);
  endtask

  task automatic fb(logic [3:0] p, bit v, string req);
    fbit_valid = 1; fbit_pos = p; fbit_val = v;
    @(negedge clk);
    fbit_valid = 0;
    if (m_mode == 1 && p == 11) begin
      if (m_fhave && v == m_fprev) exp_a = v;
      m_fprev = v; m_fhave = 1;
    end
    check(req);
  endtask

  task automatic fdl(bit b, bit sy, string req);
    fdl_valid = 1; fdl_bit = b; fdl_sync = sy;
    @(negedge clk);
    fdl_valid = 0; fdl_sync = 0;
    if (m_mode == 2) begin
      if (sy) m_pos = 0;
      m_sh = {m_sh[14:0], b};
      if (m_pos == 15) begin
        bit h = (m_sh == 16'h00FF);
        m_run = h ? (m_run == 16 ? 16 : m_run + 1) : 0;
        m_hits += h;
        if (m_run == 16) exp_a = 1;
        else if (m_grp == 15 && m_hits <= 14) exp_a = 0;
        if (m_grp == 15) begin m_grp = 0; m_hits = 0; end else m_grp++;
        m_pos = 0;
      end else m_pos++;
    end
    check(req);
  endtask

  task automatic b2_block(int zeros);
    int ones = 256 - zeros;
    for (int i = 0; i < 256; i++) begin
      logic [7:0] d = 8'($urandom(seed));
      seed++;
      d[6] = (i < ones);
      if (($urandom(seed) & 7) == 0) fb(11, 1, "R10");
      if (($urandom(seed) & 15) == 0) fdl(0, 0, "R10");
      ch(d, (zeros >= 254) ? "R2" : "R3");
    end
  endtask

  task automatic grp_send(bit h, bit sy, string req);
    logic [15:0] w = h ? 16'h00FF : 16'($urandom(seed));
    if (!h && w == 16'h00FF) w = 16'h01FF;
    for (int i = 15; i >= 0; i--) fdl(w[i], sy && i == 15, req);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: alarm=%b expected=%b", alarm, exp_a);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1;
    @(negedge clk);
    check("R1");
    // bit-2 mode: directed thresholds and random counts
    b2_block(256);
    b2_block(253);
    b2_block(254);
    b2_block(0);
    b2_block(255);
    for (int k = 0; k < 3; k++) b2_block(250 + ($urandom(seed) % 7));
    b2_block(255);
    for (int k = 0; k < 20; k++) ch(8'h00, "R4");
    repeat (3) idle("R4");
    // F-bit mode: change clears alarm, partial channel block discarded
    set_mode(0, 1, "R9");
    for (int k = 0; k < 300; k++) ch(8'h00, "R10");
    fb(11, 1, "R5"); fb(3, 1, "R5"); fb(11, 1, "R5");
    fb(11, 0, "R5"); fb(11, 1, "R5"); fb(5, 0, "R5"); fb(11, 0, "R5"); fb(11, 0, "R5");
    fb(11, 1, "R5"); fb(11, 1, "R5");
    for (int k = 0; k < 60; k++) fb(($urandom(seed) % 3 == 0) ? 4'd7 : 4'd11, $urandom(seed) % 4 != 0, "R5");
    fb(11, 1, "R5"); fb(11, 1, "R5");
    // ESF mode
    set_mode(1, 0, "R9");
    set_mode(1, 1, "R9");
    for (int k = 0; k < 16; k++) grp_send(1, k == 0, "R6");
    for (int k = 0; k < 16; k++) grp_send(k != 5, 0, "R7");
    for (int k = 0; k < 16; k++) grp_send(k != 2 && k != 9, 0, "R7");
    for (int k = 0; k < 16; k++) grp_send(1, 0, "R6");
    for (int k = 0; k < 5; k++) fdl($urandom(seed) & 1, 0, "R8");
    for (int k = 0; k < 16; k++) grp_send(1, k == 0, "R8");
    for (int k = 0; k < 20; k++) ch(8'h00, "R10");
    for (int k = 0; k < 10; k++) fb(11, 1, "R10");
    for (int k = 0; k < 48; k++) grp_send($urandom(seed) % 8 != 0, 0, "R7");
    for (int k = 0; k < 16; k++) grp_send(1, 0, "R6");
    // back to bit-2 mode
    set_mode(0, 0, "R9");
    b2_block(254);
    set_mode(0, 1, "R9");
    idle("R9");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule